// File: doc/BRIEF.md
# Store Write Policy and Line Validity Tracker

This block sits beside a data cache controller and decides, for every store, what the outbound write channel must do: nothing, a single-word write, or a burst of the whole cache line. To make that choice it keeps one valid bit per word of every line. A line counts as fully valid once a refill has brought in the whole line, or once full-word stores have covered every word of it.

Write-back mode is a static parameter. With write-back off, every store goes out as a single write, whether it hit or missed. With write-back on, a store that hits a fully valid line is sent as a line burst. Any other store falls back to a single write. The tag compare, the data arrays and the stream protocol belong to neighbouring logic. This block only receives refill, drop (reallocate or invalidate) and store events, and returns one registered command per store.

Top module: `wr_policy_tracker`

## Requirements
- R1: After reset, and in the cycle after any cycle with no store, `cmd` is 0 (none). Command encoding: 0 = none, 1 = single write, 2 = line burst.
- R2: Each store (`st_en` high) produces a nonzero `cmd` in the following cycle, with `cmd_line` equal to that store's line index.
- R3: With `WRITEBACK` = 0, every store yields `cmd` = 1, whether it hit or missed and however full its line is.
- R4: With `WRITEBACK` = 1, `cmd` = 2 is issued only for a store that hits a line that is fully valid after this cycle's updates. Every other store yields 1.
- R5: A refill event (`refill_en`) marks every word of `refill_line` valid in one cycle.
- R6: A full-word store (`st_size` = 2) that hits marks its own word valid and no other word. The store that completes the line is itself issued as a burst.
- R7: Byte stores (`st_size` = 0) and halfword stores (`st_size` = 1) never mark any word valid.
- R8: A drop event (`drop_en`) clears every valid bit of `drop_line`.
- R9: A store miss (`st_hit` = 0) yields `cmd` = 1 and marks no word valid.
- R10: When events coincide on the same line, a refill wins over a drop, and a drop wins over a store's word update. The store's command uses the line state that results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refill_en | input | 1 | Whole-line refill completed this cycle |
| refill_line | input | $clog2(LINES) | Line index of the refill |
| drop_en | input | 1 | Line reallocated or invalidated this cycle |
| drop_line | input | $clog2(LINES) | Line index of the drop |
| st_en | input | 1 | Store event this cycle |
| st_line | input | $clog2(LINES) | Line index of the store |
| st_word | input | $clog2(WORDS) | Word offset of the store within the line |
| st_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| st_hit | input | 1 | Store hit in the cache |
| cmd | output | 2 | Registered write command: 0 none, 1 single, 2 burst |
| cmd_line | output | $clog2(LINES) | Line index belonging to `cmd` |

## Verification
On every cycle the assertions check the following: a command follows each store and none follows an idle cycle; the command carries the store's line; a miss, or a write-through build, never bursts; and a hit that coincides with a refill of its own line bursts when write-back is on. Some behaviours show up only over a sequence of events: valid bits built up store by store, byte and halfword stores leaving them untouched, drops clearing a line, and a burst appearing exactly on the word that completes a line. For those, the bench runs directed scenarios and a random event stream. Two instances, one with write-back on and one with it off, are compared against a behavioural model on every clock.

// File: rtl/wr_policy_tracker.sv
module wr_policy_tracker #(
  parameter int LINES     = 16,
  parameter int WORDS     = 8,
  parameter bit WRITEBACK = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     refill_en,
  input  logic [$clog2(LINES)-1:0] refill_line,
  input  logic                     drop_en,
  input  logic [$clog2(LINES)-1:0] drop_line,
  input  logic                     st_en,
  input  logic [$clog2(LINES)-1:0] st_line,
  input  logic [$clog2(WORDS)-1:0] st_word,
  input  logic [1:0]               st_size,
  input  logic                     st_hit,
  output logic [1:0]               cmd,
  output logic [$clog2(LINES)-1:0] cmd_line
);
  localparam int LW = $clog2(LINES);
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_SINGLE = 2'd1, CMD_BURST = 2'd2;
  localparam logic [1:0] SZ_WORD = 2'd2;

  logic [WORDS-1:0] vmask [LINES];
  logic [WORDS-1:0] st_cur, st_next;
  logic             word_set, st_full;
  logic [1:0]       cmd_d;

  assign word_set = st_en && st_hit && (st_size == SZ_WORD);
  assign st_cur   = vmask[st_line];

  always_comb begin
    if (refill_en && refill_line == st_line)   st_next = '1;
    else if (drop_en && drop_line == st_line)  st_next = '0;
    else if (word_set)                         st_next = st_cur | (WORDS'(1) << st_word);
    else                                       st_next = st_cur;
  end

  assign st_full = &st_next;
  assign cmd_d = !st_en ? CMD_NONE :
                 (WRITEBACK && st_hit && st_full) ? CMD_BURST : CMD_SINGLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) vmask[l] <= '0;
      cmd      <= CMD_NONE;
      cmd_line <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) begin
        if (refill_en && refill_line == LW'(l))                vmask[l] <= '1;
        else if (drop_en && drop_line == LW'(l))               vmask[l] <= '0;
        else if (word_set && st_line == LW'(l))                vmask[l][st_word] <= 1'b1;
      end
      cmd      <= cmd_d;
      cmd_line <= st_en ? st_line : cmd_line;
    end
  end

  AST_IDLE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en |=> cmd == CMD_NONE); // R1
  AST_STORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |=> (cmd != CMD_NONE) && (cmd_line == $past(st_line))); // R2
  AST_WT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITEBACK && st_en) |=> cmd == CMD_SINGLE); // R3
  AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en && !st_hit) |=> cmd == CMD_SINGLE); // R9
  AST_REFILL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (WRITEBACK && st_en && st_hit && refill_en && refill_line == st_line) |=> cmd == CMD_BURST); // R10
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 2'd3); // R4
endmodule

// File: tb/tb_wr_policy_tracker.sv
module tb_wr_policy_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int WORDS = 8;
  localparam int LW = $clog2(LINES);
  localparam int WW = $clog2(WORDS);

  logic clk = 0, rst_n = 0;
  logic refill_en = 0, drop_en = 0, st_en = 0, st_hit = 0;
  logic [LW-1:0] refill_line = '0, drop_line = '0, st_line = '0;
  logic [WW-1:0] st_word = '0;
  logic [1:0] st_size = '0;
  logic [1:0] cmd_wb, cmd_wt;
  logic [LW-1:0] line_wb, line_wt;

  int errors = 0, checks = 0;
  bit [WORDS-1:0] mv [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_policy_tracker #(.LINES(LINES), .WORDS(WORDS), .WRITEBACK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .refill_en(refill_en), .refill_line(refill_line),
    .drop_en(drop_en), .drop_line(drop_line), .st_en(st_en), .st_line(st_line),
    .st_word(st_word), .st_size(st_size), .st_hit(st_hit), .cmd(cmd_wb), .cmd_line(line_wb));

  wr_policy_tracker #(.LINES(LINES), .WORDS(WORDS), .WRITEBACK(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .refill_en(refill_en), .refill_line(refill_line),
    .drop_en(drop_en), .drop_line(drop_line), .st_en(st_en), .st_line(st_line),
    .st_word(st_word), .st_size(st_size), .st_hit(st_hit), .cmd(cmd_wt), .cmd_line(line_wt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit rf, input int rfl, input bit dr, input int drl,
                      input bit st, input int sl, input int sw, input int sz,
                      input bit hit, input string req);
    bit [WORDS-1:0] nxt;
    int cnt, exp_wb, exp_wt;
    @(negedge clk);
    refill_en = rf; refill_line = LW'(rfl); drop_en = dr; drop_line = LW'(drl);
    st_en = st; st_line = LW'(sl); st_word = WW'(sw); st_size = 2'(sz); st_hit = hit;
    // behavioural model: the line state this store sees after same-cycle events
    if (rf && rfl == sl) nxt = '1;
    else if (dr && drl == sl) nxt = '0;
    else begin
      nxt = mv[sl];
      if (st && hit && sz == 2) nxt[sw] = 1'b1;
    end
    cnt = 0;
    for (int w = 0; w < WORDS; w++) if (nxt[w]) cnt++;
    exp_wb = !st ? 0 : (hit && cnt == WORDS) ? 2 : 1;
    exp_wt = st ? 1 : 0;
    for (int l = 0; l < LINES; l++) begin
      if (rf && rfl == l) mv[l] = '1;
      else if (dr && drl == l) mv[l] = '0;
      else if (st && hit && sz == 2 && sl == l) mv[l][sw] = 1'b1;
    end
    @(posedge clk); #1;
    chk({req, " cmd wb"}, int'(cmd_wb), exp_wb);
    chk({req, " cmd wt"}, int'(cmd_wt), exp_wt);
    if (st) begin
      chk({"R2 line wb ", req}, int'(line_wb), sl);
      chk({"R2 line wt ", req}, int'(line_wt), sl);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < LINES; l++) mv[l] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset wb", int'(cmd_wb), 0);
    chk("R1 reset wt", int'(cmd_wt), 0);
    @(negedge clk); rst_n = 1;
    step(0,0,0,0, 0,0,0,0,0, "R1 idle");
    // R3 / R9: misses and hits on an empty line
    step(0,0,0,0, 1,1,0,2,0, "R9 miss word");
    step(0,0,0,0, 1,1,0,2,1, "R3 hit word empty line");
    step(0,0,0,0, 1,1,1,2,0, "R9 miss sets nothing");
    // R5: refill then a hit
    step(1,3,0,0, 0,0,0,0,0, "R5 refill");
    step(0,0,0,0, 1,3,4,2,1, "R5 hit after refill");
    step(0,0,0,0, 1,3,2,0,1, "R4 byte on full line");
    step(0,0,0,0, 1,3,2,0,0, "R9 miss on full line");
    // R6: word coverage, burst on the completing word
    for (int w = 0; w < WORDS; w++) step(0,0,0,0, 1,5,w,2,1, "R6 cover");
    step(0,0,0,0, 1,5,0,1,1, "R6 half after cover");
    // R7: byte/halfword stores mark nothing
    step(0,0,0,0, 1,6,7,1,1, "R7 half");
    step(0,0,0,0, 1,6,7,0,1, "R7 byte");
    for (int w = 0; w < WORDS-1; w++) step(0,0,0,0, 1,6,w,2,1, "R7 words");
    step(0,0,0,0, 1,6,0,2,1, "R7 word7 still missing");
    step(0,0,0,0, 1,6,7,2,1, "R6 last word");
    // R8: drop clears
    step(0,0,1,3, 0,0,0,0,0, "R8 drop");
    step(0,0,0,0, 1,3,4,2,1, "R8 after drop");
    // R10: coincident events
    step(1,9,0,0, 1,9,0,0,1, "R10 refill+store");
    step(0,0,1,9, 1,9,0,2,1, "R10 drop+store");
    step(1,10,1,10, 1,10,0,1,1, "R10 refill+drop+store");
    step(0,0,0,0, 1,10,0,1,1, "R10 refill beat drop");
    // random stream
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0,15) == 0, $urandom_range(0,LINES-1),
           $urandom_range(0,15) == 0, $urandom_range(0,LINES-1),
           $urandom_range(0,3) != 0, $urandom_range(0,3), $urandom_range(0,WORDS-1),
           $urandom_range(0,2), $urandom_range(0,4) != 0, "R4 random");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule